// File: doc/BRIEF.md
# Supply and Activity Supervisor Reset

This block drives a processor reset from two sources: a digital supply-good flag coming from an off-block threshold comparator, and a watchdog. Reset is raised while the supply flag is low. It is released only after the flag has stayed high without a break for a fixed hold-off time. The default hold-off is 200 ms at a 200 MHz clock. The same hold-off applies after a brownout and after a watchdog expiry.

The watchdog does not use a dedicated kick pin. It watches a two-wire serial bus, and every START condition restarts it. A START is SDA going from high to low while SCL is high. The host can pick one of three timeout periods, or switch the watchdog off, with a two-bit code and a write strobe. A write-protect pin freezes that choice. Both SCL and SDA are only observed and never driven.

All pin inputs pass through two-flop synchronizers before any decision is made. Both reset polarities are provided.

Top module: `supv_reset_wdog`

## Requirements
- R1: While `arst_ni` is low, `rst_o` is 1. At all times `rst_no` is the inverse of `rst_o`.
- R2: When `vsup_ok_i` rises and stays high, `rst_o` falls exactly HOLD_CYCLES+2 rising clock edges after the change: two edges of synchronizer, then HOLD_CYCLES edges of hold-off count.
- R3: When `vsup_ok_i` falls, `rst_o` is 1 after the second rising edge. It is still 0 after the first edge if it was 0 before.
- R4: A low pulse of `vsup_ok_i` during the hold-off restarts the count from zero. Release then comes HOLD_CYCLES+2 edges after the flag returns high.
- R5: A START (SDA falling while SCL is high, both synchronized) restarts the watchdog. An SDA fall while SCL is low does not restart it.
- R6: If no START arrives, `rst_o` rises L+3 edges after the last SDA fall that formed a START. L is the selected period. The reset then stays high for exactly HOLD_CYCLES cycles.
- R7: Period code `wdsel_i` = 00 selects WD_SHORT_CYC, 01 selects WD_MID_CYC, 10 selects WD_LONG_CYC, and 11 turns the watchdog off. With the watchdog off, no watchdog reset ever occurs. The code after `arst_ni` is WD_SEL_INIT (default 00).
- R8: A strobe on `wdsel_we_i` loads `wdsel_i` into the period register only while the synchronized `wp_i` is low. While `wp_i` is high the strobe has no effect.
- R9: The watchdog counter is held at zero while reset is active. After any release with no START, the next watchdog reset comes exactly L cycles later.

Parameters: HOLD_CYCLES, WD_SHORT_CYC, WD_MID_CYC, WD_LONG_CYC, WD_SEL_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous power-on reset of the block logic, active low |
| vsup_ok_i | input | 1 | Supply above threshold flag from the comparator |
| scl_i | input | 1 | Serial bus clock line, observed only |
| sda_i | input | 1 | Serial bus data line, observed only |
| wp_i | input | 1 | Write-protect pin; high locks the period code |
| wdsel_i | input | 2 | Watchdog period code to load |
| wdsel_we_i | input | 1 | Load strobe for the period code |
| rst_o | output | 1 | Processor reset, active high |
| rst_no | output | 1 | Processor reset, active low |

## Verification
A supply change shows on the reset pin two edges after the pin moves. A release needs a further HOLD_CYCLES edges, and a START counts from the third edge after SDA falls, so a watchdog reset lands L+3 edges after that fall. The bench keeps a behavioural model that advances on each rising edge and compares both reset pins at every falling edge. Directed measurements count rising edges from the falling edge on which a pin was driven until the reset changes, and compare the count against those figures. This makes an off-by-one latency in any path show up as a counted mismatch.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Period in cycles for a given code; the off code returns the long value
  // (never used for expiry).
  function automatic int unsigned wd_limit(wd_sel_e s, int unsigned p_short,
                                           int unsigned p_mid, int unsigned p_long);
    case (s)
      WD_SHORT: return p_short;
      WD_MID:   return p_mid;
      default:  return p_long;
    endcase
  endfunction

  // Hold-off finished once the count reaches the target.
  function automatic logic holdoff_done(int unsigned cnt, int unsigned target);
    return cnt >= target;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/supv_start_det.sv
module supv_start_det (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o
);
  logic sda_d_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sda_d_q <= 1'b1;
    else          sda_d_q <= sda_s_i;
  end

  // falling data line while the clock line is high
  assign start_o = sda_d_q & ~sda_s_i & scl_s_i;
endmodule

// File: rtl/supv_holdoff.sv
module supv_holdoff import supv_pkg::*; #(
  parameter int unsigned HOLD_CYCLES = 40_000_000
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic vok_i,
  input  logic bite_i,
  output logic rst_act_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt_q;
  logic          done;

  assign done = holdoff_done(32'(cnt_q), HOLD_CYCLES);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
    end else if (!vok_i || bite_i) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_act_o = !vok_i || !done;
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog import supv_pkg::*; #(
  parameter int unsigned WD_SHORT_CYC = 20_000_000,
  parameter int unsigned WD_MID_CYC   = 100_000_000,
  parameter int unsigned WD_LONG_CYC  = 280_000_000,
  parameter logic [1:0]  WD_SEL_INIT  = 2'b00
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       start_i,
  input  logic       rst_act_i,
  input  logic       wp_s_i,
  input  logic       sel_we_i,
  input  logic [1:0] sel_i,
  output logic       bite_o
);
  localparam int unsigned CMAX = max3(WD_SHORT_CYC, WD_MID_CYC, WD_LONG_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  wd_sel_e       sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          wd_on;

  assign lim_m1 = CW'(wd_limit(sel_q, WD_SHORT_CYC, WD_MID_CYC, WD_LONG_CYC) - 1);
  assign wd_on  = (sel_q != WD_OFF);
  assign bite_o = !rst_act_i && wd_on && !start_i && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sel_q <= wd_sel_e'(WD_SEL_INIT);
    end else if (sel_we_i && !wp_s_i) begin
      sel_q <= wd_sel_e'(sel_i);
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
    end else if (rst_act_i || !wd_on || start_i || bite_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog import supv_pkg::*; #(
  parameter int unsigned HOLD_CYCLES  = 40_000_000,
  parameter int unsigned WD_SHORT_CYC = 20_000_000,
  parameter int unsigned WD_MID_CYC   = 100_000_000,
  parameter int unsigned WD_LONG_CYC  = 280_000_000,
  parameter logic [1:0]  WD_SEL_INIT  = 2'b00
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       vsup_ok_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [1:0] wdsel_i,
  input  logic       wdsel_we_i,
  output logic       rst_o,
  output logic       rst_no
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned CW = $clog2(max3(WD_SHORT_CYC, WD_MID_CYC, WD_LONG_CYC) + 1);

  // synchronized pins: {wp, sda, scl, vok}; idle bus high, lock on at reset
  logic [3:0] pins_raw, pins_s;
  logic       vok, scl_s, sda_s, wp_s;
  logic       start_evt, bite, rst_act;

  assign pins_raw = {wp_i, sda_i, scl_i, vsup_ok_i};

  supv_sync #(.W(4), .RST_VAL(4'b1110)) u_sync (
    .clk_i(clk_i), .arst_ni(arst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  assign vok   = pins_s[0];
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[2];
  assign wp_s  = pins_s[3];

  supv_start_det u_start (
    .clk_i(clk_i), .arst_ni(arst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start_evt)
  );

  supv_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .arst_ni(arst_ni), .vok_i(vok), .bite_i(bite),
    .rst_act_o(rst_act)
  );

  supv_watchdog #(
    .WD_SHORT_CYC(WD_SHORT_CYC), .WD_MID_CYC(WD_MID_CYC),
    .WD_LONG_CYC(WD_LONG_CYC), .WD_SEL_INIT(WD_SEL_INIT)
  ) u_wd (
    .clk_i(clk_i), .arst_ni(arst_ni), .start_i(start_evt), .rst_act_i(rst_act),
    .wp_s_i(wp_s), .sel_we_i(wdsel_we_i), .sel_i(wdsel_i), .bite_o(bite)
  );

  assign rst_o  = rst_act;
  assign rst_no = ~rst_act;
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int unsigned HW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          arst_n,
  input logic          rst_o,
  input logic          rst_no,
  input logic          vok,
  input logic          start_evt,
  input logic          bite,
  input logic          wp_s,
  input logic [1:0]    sel,
  input logic [HW-1:0] hold_cnt,
  input logic [CW-1:0] wd_cnt
);
  assert_polarity_R1: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o != rst_no);

  assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> (vok && $past(vok)));

  assert_supply_low_resets_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !vok |=> rst_o);

  assert_glitch_restarts_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !vok |=> (hold_cnt == '0));

  assert_start_restarts_R5: assert property (@(posedge clk) disable iff (!arst_n)
    start_evt |=> (wd_cnt == '0));

  assert_expiry_resets_R6: assert property (@(posedge clk) disable iff (!arst_n)
    bite |=> rst_o);

  assert_off_code_idle_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (sel == 2'b11) |=> (wd_cnt == '0));

  assert_lock_holds_code_R8: assert property (@(posedge clk) disable iff (!arst_n)
    wp_s |=> $stable(sel));

  assert_count_cleared_in_reset_R9: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o |=> (wd_cnt == '0));
endmodule

bind supv_reset_wdog supv_checker #(.HW(HW), .CW(CW)) i_chk (
  .clk(clk_i), .arst_n(arst_ni), .rst_o(rst_o), .rst_no(rst_no), .vok(vok),
  .start_evt(start_evt), .bite(bite), .wp_s(wp_s), .sel(u_wd.sel_q),
  .hold_cnt(u_hold.cnt_q), .wd_cnt(u_wd.cnt_q)
);

// File: tb/test_supv_reset_wdog.sv
`timescale 1ns/1ps
module test_supv_reset_wdog;
  localparam int HOLD = 20;
  localparam int P0 = 30, P1 = 50, P2 = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic arst_n = 1'b0, vin = 1'b0, scl = 1'b1, sda = 1'b1, wp = 1'b0;
  logic [1:0] sel_in = 2'b00;
  logic we = 1'b0;
  logic rst_o, rst_no;

  int total = 0, bad = 0;

  supv_reset_wdog #(.HOLD_CYCLES(HOLD), .WD_SHORT_CYC(P0), .WD_MID_CYC(P1),
                    .WD_LONG_CYC(P2), .WD_SEL_INIT(2'b00)) i_supv_reset_wdog (
    .clk_i(clk), .arst_ni(arst_n), .vsup_ok_i(vin), .scl_i(scl), .sda_i(sda),
    .wp_i(wp), .wdsel_i(sel_in), .wdsel_we_i(we), .rst_o(rst_o), .rst_no(rst_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int vh[$], sh[$], ch[$], wh[$];
  int m_hold, m_wd, m_sel;
  int t_vok, t_rst, t_start, t_lim, t_bite;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vh = '{0, 0, 0}; sh = '{1, 1, 1}; ch = '{1, 1}; wh = '{1, 1};
      m_hold = 0; m_wd = 0; m_sel = 0;
    end else begin
      t_vok   = vh[1];
      t_rst   = (t_vok == 0 || m_hold < HOLD) ? 1 : 0;
      t_start = (sh[2] == 1 && sh[1] == 0 && ch[1] == 1) ? 1 : 0;
      t_lim   = (m_sel == 0) ? P0 : (m_sel == 1) ? P1 : P2;
      t_bite  = (t_rst == 0 && m_sel != 3 && t_start == 0 && m_wd == t_lim - 1) ? 1 : 0;
      if (t_vok == 0 || t_bite == 1) m_hold = 0;
      else if (m_hold < HOLD) m_hold++;
      if (t_rst == 1 || m_sel == 3 || t_start == 1 || t_bite == 1) m_wd = 0;
      else m_wd++;
      if (we && wh[1] == 0) m_sel = int'(sel_in);
      vh.push_front(int'(vin)); void'(vh.pop_back());
      sh.push_front(int'(sda)); void'(sh.pop_back());
      ch.push_front(int'(scl)); void'(ch.pop_back());
      wh.push_front(int'(wp));  void'(wh.pop_back());
    end
  end

  always @(negedge clk) begin
    int e;
    e = (vh[1] == 0 || m_hold < HOLD) ? 1 : 0;
    chk(int'(rst_o) == e, "R1 model rst_o", int'(rst_o), e);
    chk(rst_no == ~rst_o, "R1 polarity rst_no", int'(rst_no), int'(~rst_o));
  end

  // ---------------- helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_until(input logic want, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (rst_o == want || n > 5000) break;
    end
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge clk); sel_in = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic kick();
    sda = 1'b0; idle(3);
    scl = 1'b0; idle(2);
    sda = 1'b1; idle(2);
    scl = 1'b1; idle(2);
  endtask

  task automatic stays_low(input int n, input string req);
    int hits;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_o) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  initial begin
    int n;
    #200_000;
    bad++; total++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    idle(4);
    chk(rst_o == 1'b1, "R1 rst_o in reset", int'(rst_o), 1);
    chk(rst_no == 1'b0, "R1 rst_no in reset", int'(rst_no), 0);
    @(negedge clk); arst_n = 1'b1;
    idle(5);
    chk(rst_o == 1'b1, "R1 held with supply low", int'(rst_o), 1);

    // R2: power-up release timing
    vin = 1'b1;
    count_until(1'b0, n);
    chk(n == HOLD + 2, "R2 release latency", n, HOLD + 2);

    // R5: periodic START keeps reset away (period 00)
    for (int k = 0; k < 12; k++) begin
      kick();
      stays_low(10, "R5 kicked no reset");
    end

    // R6/R7 code 00: expiry after last START
    @(negedge clk); sda = 1'b0;
    count_until(1'b1, n);
    chk(n == P0 + 3, "R6 R7 expiry period 00", n, P0 + 3);
    sda = 1'b1;
    count_until(1'b0, n);
    chk(n == HOLD, "R6 watchdog reset length", n, HOLD);
    // R9: counter cleared during reset -> full period after release
    count_until(1'b1, n);
    chk(n == P0, "R9 full period after release", n, P0);
    count_until(1'b0, n);
    chk(n == HOLD, "R6 second reset length", n, HOLD);

    // R7: code 11 disables
    write_sel(2'b11);
    stays_low(200, "R7 off code no reset");

    // R8: locked write ignored
    wp = 1'b1; idle(3);
    write_sel(2'b00);
    stays_low(150, "R8 locked write ignored");
    wp = 1'b0; idle(3);
    write_sel(2'b01);
    @(negedge clk); sda = 1'b0;
    count_until(1'b1, n);
    chk(n == P1 + 3, "R8 R7 unlocked write period 01", n, P1 + 3);
    sda = 1'b1;
    count_until(1'b0, n);
    chk(n == HOLD, "R6 reset length period 01", n, HOLD);

    // R7 code 10 and R5 negative: SDA fall with SCL low does not restart
    write_sel(2'b10);
    @(negedge clk); sda = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 40) scl = 1'b0;
      if (n == 42) sda = 1'b1;
      if (n == 44) sda = 1'b0;
      if (n == 46) scl = 1'b1;
      if (rst_o || n > 5000) break;
    end
    chk(n == P2 + 3, "R5 R7 no restart with SCL low, period 10", n, P2 + 3);
    sda = 1'b1;
    count_until(1'b0, n);
    chk(n == HOLD, "R6 reset length period 10", n, HOLD);

    // R3: supply drop
    write_sel(2'b11);
    idle(5);
    chk(rst_o == 1'b0, "R3 running before drop", int'(rst_o), 0);
    vin = 1'b0;
    @(negedge clk);
    chk(rst_o == 1'b0, "R3 one edge after drop", int'(rst_o), 0);
    @(negedge clk);
    chk(rst_o == 1'b1, "R3 two edges after drop", int'(rst_o), 1);
    idle(10);

    // R4: glitch during hold-off restarts the count
    vin = 1'b1; idle(10);
    chk(rst_o == 1'b1, "R4 still in hold-off", int'(rst_o), 1);
    vin = 1'b0; idle(1);
    vin = 1'b1;
    count_until(1'b0, n);
    chk(n == HOLD + 2, "R4 release after glitch", n, HOLD + 2);
    stays_low(100, "R7 off code after brownout");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule